// File: doc/BRIEF.md
# Line Uniformity Statistics Engine

This block watches a stream of digitized pixel samples from a linear image sensor and measures how uniform one scan line is. Every sample carries a tag that says whether it comes from a light-sensing pixel that counts toward the statistics. Shield pixels, reference pixels and dummy pixels are tagged out and have no effect. A first-pixel flag opens a line and a last-pixel flag closes it. While the line streams in, the block keeps a running sum, a count, the highest and lowest sample, and a signed running total of the difference inside each odd/even pixel pair.

When the line closes, one shared restoring divider runs three divisions in turn. The first gives the mean level. The second gives the larger deviation of an extreme from the mean, as a percentage of the mean. The third gives the odd/even imbalance as a percentage of the mean. Both percentages are fixed-point values with eight fractional bits. All results are published together with a single-cycle done pulse and stay unchanged until the next pulse. Samples that arrive while the divisions run are dropped and raise an overrun flag.

Top module: `lstat_top`

## Requirements
- R1: Samples with `in_pix_ok` low change none of the results, whatever their value.
- R2: `res_avg` equals floor(S / N), where S is the sum and N is the count of the tagged samples of the line.
- R3: `res_max` and `res_min` are the largest and smallest tagged sample. `res_dev_hi` = `res_max` − `res_avg` and `res_dev_lo` = `res_avg` − `res_min`.
- R4: `res_nonuni` equals floor(max(`res_dev_hi`, `res_dev_lo`) × 25600 / `res_avg`). This is a percentage with 8 fractional bits, so 256 stands for 1 %.
- R5: Tagged samples are paired in arrival order: the 1st with the 2nd, the 3rd with the 4th, and so on. A final tagged sample with no partner takes part in no pair.
- R6: With D the sum over all pairs of (first member − second member), `res_imbal` is the two's-complement value sign(D) × floor(2·|D| × 25600 / S).
- R7: A line of 5150 tagged samples of value 65535 gives exact results, with no accumulator wraparound.
- R8: If N = 0, or if the mean comes out as 0, then `res_nonuni` = 0xFFFFFFFF, `res_imbal` = 0x7FFFFFFF and `res_err` = 1. When N = 0, the mean, extremes and deviations read 0. `res_err` is 0 on any other line.
- R9: `res_done` is high for exactly one cycle per closed line. All result outputs change only in the cycle in which `res_done` rises.
- R10: A sample offered between the closing sample and the done pulse is ignored and sets `overrun` to 1. `overrun` returns to 0 when the next accepted sample that has `in_first` set arrives.
- R11: After reset, every result output, `res_done`, `res_err` and `overrun` are 0.
- R12: An accepted sample with `in_first` set discards any partly accumulated line and starts a new one that includes that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | A sample is present this cycle |
| in_pix_ok | input | 1 | The sample belongs to a counted pixel |
| in_first | input | 1 | The sample opens a line |
| in_last | input | 1 | The sample closes a line |
| in_data | input | DATA_W | Sample value, unsigned |
| res_done | output | 1 | One-cycle pulse: new results published |
| res_avg | output | DATA_W | Mean of the tagged samples |
| res_max | output | DATA_W | Largest tagged sample |
| res_min | output | DATA_W | Smallest tagged sample |
| res_dev_hi | output | DATA_W | Maximum minus mean |
| res_dev_lo | output | DATA_W | Mean minus minimum |
| res_nonuni | output | PCT_W | Extreme deviation as a percentage of the mean, 8 fractional bits |
| res_imbal | output | PCT_W | Signed odd/even imbalance as a percentage, 8 fractional bits |
| res_err | output | 1 | The mean was zero, so the percentages are saturated |
| overrun | output | 1 | A sample arrived while the divisions were running |

## Verification
The embedded properties assume that a line holds no more than MAX_PIX tagged samples and that the divider is never started while it is busy. The stimulus respects both: random lines stay well under the limit, and only the two directed full-length lines reach it exactly. The same properties also assume that a closed line always ends with the done pulse. The bench confirms this by waiting for the pulse after every closing sample. Misuse is provoked only through the documented path, which is samples offered during the division window, and the bench then checks that those samples changed neither the count nor the published values.

// File: rtl/lstat_pkg.sv
// Shared definitions for the line uniformity statistics engine.
// Assumes: nothing beyond being compiled before the modules that import it.
package lstat_pkg;

    // Sequencer states: idle, the three divisions, then publication
    typedef enum logic [2:0] {
        LS_IDLE,
        LS_MEAN,
        LS_NONUNI,
        LS_IMBAL,
        LS_PUB
    } lstat_state_t;

endpackage

// File: rtl/lstat_accum.sv
// Per-line accumulator: count, sum, extremes and the signed odd/even pair sum.
// Assumes: 'take' is low whenever the sequencer is busy; a line holds at most
// MAX_PIX counted samples, so SUM_W and DIF_W cannot wrap.
module lstat_accum #(
    parameter int DATA_W  = 16,
    parameter int MAX_PIX = 5150,
    parameter int CNT_W   = 13,
    parameter int SUM_W   = 29,
    parameter int DIF_W   = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    first,
    input  logic                    pix_ok,
    input  logic [DATA_W-1:0]       data,
    output logic [CNT_W-1:0]        cnt_q,
    output logic [SUM_W-1:0]        sum_q,
    output logic signed [DIF_W-1:0] dsum_q,
    output logic [DATA_W-1:0]       max_q,
    output logic [DATA_W-1:0]       min_q
);

    logic                    pend_q;     // an odd member waits for its partner
    logic [DATA_W-1:0]       odd_q;      // value of the waiting odd member
    logic [CNT_W-1:0]        b_cnt;
    logic [SUM_W-1:0]        b_sum;
    logic signed [DIF_W-1:0] b_dsum;
    logic [DATA_W-1:0]       b_max;
    logic [DATA_W-1:0]       b_min;
    logic                    b_pend;
    logic signed [DATA_W:0]  pair_diff;

    // Starting point for this sample: fresh line on a first flag, else carry on
    always_comb begin
        b_cnt     = first ? '0 : cnt_q;
        b_sum     = first ? '0 : sum_q;
        b_dsum    = first ? '0 : dsum_q;
        b_max     = first ? '0 : max_q;
        b_min     = first ? '1 : min_q;
        b_pend    = first ? 1'b0 : pend_q;
        pair_diff = $signed({1'b0, odd_q}) - $signed({1'b0, data});
    end

    // Fold one accepted sample into the line statistics
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sum_q  <= '0;
            dsum_q <= '0;
            max_q  <= '0;
            min_q  <= '1;
            pend_q <= 1'b0;
            odd_q  <= '0;
        end else if (take) begin
            if (pix_ok) begin
                cnt_q <= b_cnt + 1'b1;
                sum_q <= b_sum + SUM_W'(data);
                max_q <= (data > b_max) ? data : b_max;
                min_q <= (data < b_min) ? data : b_min;
                odd_q <= data;
                if (b_pend) begin
                    dsum_q <= b_dsum + DIF_W'(pair_diff);
                    pend_q <= 1'b0;
                end else begin
                    dsum_q <= b_dsum;
                    pend_q <= 1'b1;
                end
            end else begin
                cnt_q  <= b_cnt;
                sum_q  <= b_sum;
                dsum_q <= b_dsum;
                max_q  <= b_max;
                min_q  <= b_min;
                pend_q <= b_pend;
            end
        end
    end

    // R3: once anything is counted the extremes are ordered
    a_r3_extreme_order: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (min_q <= max_q));

    // R5: an odd member of a pair leaves the pair sum untouched
    a_r5_odd_no_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pix_ok && !first && !pend_q) |=> $stable(dsum_q));

    // R7: the running sum never wraps inside a line
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pix_ok && !first) |=> (sum_q >= $past(sum_q)));

    // R7: the count stays within the line size the widths were chosen for
    a_r7_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_PIX));

endmodule

// File: rtl/lstat_div.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
// Assumes: start is pulsed only while idle; den is nonzero.
module lstat_div #(
    parameter int NUM_W = 45,
    parameter int DEN_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic [DEN_W:0]    shifted;
    logic [DEN_W+1:0]  trial;
    logic              fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {rem_q, quot[NUM_W-1]};
        trial   = {1'b0, shifted} - {2'b00, den_q};
        fits    = !trial[DEN_W+1];
    end

    // Shift-and-subtract iteration with a step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            quot   <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quot   <= num;
                den_q  <= den;
                rem_q  <= '0;
                step_q <= STEP_W'(NUM_W);
                busy   <= 1'b1;
            end else if (busy) begin
                rem_q  <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
                quot   <= {quot[NUM_W-2:0], fits};
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R2: the sequencer never restarts a division in flight
    a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R2: the partial remainder stays below the divisor
    a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_q < den_q));

    // R9: completion is a single-cycle event that ends a busy period
    a_r9_div_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/lstat_top.sv
// Line uniformity statistics engine: accumulates counted samples of one line,
// then runs mean, extreme-deviation and odd/even imbalance divisions in turn on
// one shared divider and publishes every result with a single done pulse.
// Assumes: a line holds at most MAX_PIX counted samples; NUM_W exceeds PCT_W.
module lstat_top #(
    parameter int DATA_W  = 16,
    parameter int MAX_PIX = 5150,
    parameter int FRAC_W  = 8,
    parameter int PCT_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic                    in_pix_ok,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    res_done,
    output logic [DATA_W-1:0]       res_avg,
    output logic [DATA_W-1:0]       res_max,
    output logic [DATA_W-1:0]       res_min,
    output logic [DATA_W-1:0]       res_dev_hi,
    output logic [DATA_W-1:0]       res_dev_lo,
    output logic [PCT_W-1:0]        res_nonuni,
    output logic signed [PCT_W-1:0] res_imbal,
    output logic                    res_err,
    output logic                    overrun
);

    import lstat_pkg::*;

    localparam int CNT_W  = $clog2(MAX_PIX + 1);
    localparam int SUM_W  = DATA_W + CNT_W;
    localparam int DIF_W  = SUM_W + 1;
    localparam int SCALE  = 100 * (1 << FRAC_W);
    localparam int SCL_W  = $clog2(SCALE + 1);
    localparam int NUM_W  = SUM_W + 1 + SCL_W;
    localparam int DEN_W  = SUM_W;
    localparam logic [PCT_W-1:0] PCT_SAT = {PCT_W{1'b1}};
    localparam logic [PCT_W-1:0] IMB_SAT = {1'b0, {(PCT_W-1){1'b1}}};
    localparam int IMB_LIM = 2 * SCALE;

    logic [CNT_W-1:0]        acc_cnt;
    logic [SUM_W-1:0]        acc_sum;
    logic signed [DIF_W-1:0] acc_dsum;
    logic [DATA_W-1:0]       acc_max;
    logic [DATA_W-1:0]       acc_min;

    lstat_state_t      state_q;
    logic              last_q;
    logic              busy;
    logic              take;
    logic              div_start;
    logic [NUM_W-1:0]  div_num;
    logic [DEN_W-1:0]  div_den;
    logic              div_busy;
    logic              div_done;
    logic [NUM_W-1:0]  div_quot;

    logic [DATA_W-1:0] avg_w, mx_w, mn_w;
    logic [PCT_W-1:0]  nonuni_w, imbal_w;
    logic              err_w;
    logic              imb_neg;

    logic [DATA_W-1:0] avg_now, dev_a, dev_b, dev_big;
    logic [NUM_W-1:0]  nonuni_num, imbal_num;
    logic [SUM_W-1:0]  dsum_abs;
    logic [PCT_W-1:0]  quot_sat;
    logic [PCT_W-1:0]  imb_mag;

    // Sample acceptance: only while no line is being finished
    assign busy = (state_q != LS_IDLE) || last_q;
    assign take = in_vld && !busy;

    lstat_accum #(
        .DATA_W (DATA_W),
        .MAX_PIX(MAX_PIX),
        .CNT_W  (CNT_W),
        .SUM_W  (SUM_W),
        .DIF_W  (DIF_W)
    ) i_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .first (in_first),
        .pix_ok(in_pix_ok),
        .data  (in_data),
        .cnt_q (acc_cnt),
        .sum_q (acc_sum),
        .dsum_q(acc_dsum),
        .max_q (acc_max),
        .min_q (acc_min)
    );

    lstat_div #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W)
    ) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quot (div_quot)
    );

    // Operand preparation for the second and third divisions
    always_comb begin
        avg_now    = div_quot[DATA_W-1:0];
        dev_a      = mx_w - avg_now;
        dev_b      = avg_now - mn_w;
        dev_big    = (dev_a > dev_b) ? dev_a : dev_b;
        nonuni_num = NUM_W'(dev_big) * NUM_W'(SCALE);
        dsum_abs   = acc_dsum[DIF_W-1] ? SUM_W'(-acc_dsum) : SUM_W'(acc_dsum);
        imbal_num  = NUM_W'({dsum_abs, 1'b0}) * NUM_W'(SCALE);
        quot_sat   = (|div_quot[NUM_W-1:PCT_W]) ? PCT_SAT : div_quot[PCT_W-1:0];
        imb_mag    = div_quot[PCT_W-1:0];
    end

    // Registers the closing sample so the sequencer sees the final totals
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= take && in_last;
    end

    // Overrun flag: set by samples during the busy window, cleared by a new line
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (in_vld && busy)     overrun <= 1'b1;
        else if (take && in_first)   overrun <= 1'b0;
    end

    // Division sequencer and result publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LS_IDLE;
            div_start  <= 1'b0;
            div_num    <= '0;
            div_den    <= '0;
            avg_w      <= '0;
            mx_w       <= '0;
            mn_w       <= '0;
            nonuni_w   <= '0;
            imbal_w    <= '0;
            err_w      <= 1'b0;
            imb_neg    <= 1'b0;
            res_done   <= 1'b0;
            res_avg    <= '0;
            res_max    <= '0;
            res_min    <= '0;
            res_dev_hi <= '0;
            res_dev_lo <= '0;
            res_nonuni <= '0;
            res_imbal  <= '0;
            res_err    <= 1'b0;
        end else begin
            div_start <= 1'b0;
            res_done  <= 1'b0;
            case (state_q)
                LS_IDLE: begin
                    if (last_q) begin
                        if (acc_cnt == '0) begin
                            avg_w    <= '0;
                            mx_w     <= '0;
                            mn_w     <= '0;
                            nonuni_w <= PCT_SAT;
                            imbal_w  <= IMB_SAT;
                            err_w    <= 1'b1;
                            state_q  <= LS_PUB;
                        end else begin
                            mx_w      <= acc_max;
                            mn_w      <= acc_min;
                            err_w     <= 1'b0;
                            div_num   <= NUM_W'(acc_sum);
                            div_den   <= DEN_W'(acc_cnt);
                            div_start <= 1'b1;
                            state_q   <= LS_MEAN;
                        end
                    end
                end
                LS_MEAN: begin
                    if (div_done) begin
                        avg_w <= avg_now;
                        if (avg_now == '0) begin
                            nonuni_w <= PCT_SAT;
                            imbal_w  <= IMB_SAT;
                            err_w    <= 1'b1;
                            state_q  <= LS_PUB;
                        end else begin
                            div_num   <= nonuni_num;
                            div_den   <= DEN_W'(avg_now);
                            div_start <= 1'b1;
                            state_q   <= LS_NONUNI;
                        end
                    end
                end
                LS_NONUNI: begin
                    if (div_done) begin
                        nonuni_w  <= quot_sat;
                        imb_neg   <= acc_dsum[DIF_W-1];
                        div_num   <= imbal_num;
                        div_den   <= acc_sum;
                        div_start <= 1'b1;
                        state_q   <= LS_IMBAL;
                    end
                end
                LS_IMBAL: begin
                    if (div_done) begin
                        imbal_w <= imb_neg ? (~imb_mag + 1'b1) : imb_mag;
                        state_q <= LS_PUB;
                    end
                end
                LS_PUB: begin
                    res_avg    <= avg_w;
                    res_max    <= mx_w;
                    res_min    <= mn_w;
                    res_dev_hi <= mx_w - avg_w;
                    res_dev_lo <= avg_w - mn_w;
                    res_nonuni <= nonuni_w;
                    res_imbal  <= imbal_w;
                    res_err    <= err_w;
                    res_done   <= 1'b1;
                    state_q    <= LS_IDLE;
                end
                default: state_q <= LS_IDLE;
            endcase
        end
    end

    // R9: the done pulse lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);

    // R9: published values hold between done pulses
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> ($stable(res_avg) && $stable(res_nonuni) &&
                       $stable(res_imbal) && $stable(res_err)));

    // R10: a sample offered while busy raises the overrun flag
    a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && busy) |=> overrun);

    // R10: a sample offered while busy does not reach the counter
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(acc_cnt));

    // R3: without an error the mean lies between the extremes
    a_r3_mean_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !res_err) |-> (res_min <= res_avg && res_avg <= res_max));

    // R8: an error always comes with a saturated non-uniformity figure
    a_r8_err_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_err) |-> (res_nonuni == PCT_SAT));

    // R6: the imbalance magnitude is bounded by two hundred percent
    a_r6_imbal_range: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !res_err) |-> (res_imbal <= PCT_W'(IMB_LIM) &&
                                    res_imbal >= -PCT_W'(IMB_LIM)));

endmodule

// File: tb/test_lstat_top.sv
// Self-checking bench for lstat_top: directed corner lines plus seeded random lines.
module test_lstat_top;

    localparam int DW = 16;
    localparam int NMAX = 5200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0, in_pix_ok = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic        res_done, res_err, overrun;
    logic [DW-1:0] res_avg, res_max, res_min, res_dev_hi, res_dev_lo;
    logic [31:0] res_nonuni;
    logic signed [31:0] res_imbal;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    int unsigned pix [NMAX];
    bit          okf [NMAX];
    int          npix;

    longint e_avg, e_max, e_min, e_hi, e_lo, e_nonuni, e_imbal, e_err;

    always #10 clk = ~clk;

    lstat_top i_lstat_top (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_pix_ok(in_pix_ok),
        .in_first(in_first), .in_last(in_last), .in_data(in_data),
        .res_done(res_done), .res_avg(res_avg), .res_max(res_max), .res_min(res_min),
        .res_dev_hi(res_dev_hi), .res_dev_lo(res_dev_lo), .res_nonuni(res_nonuni),
        .res_imbal(res_imbal), .res_err(res_err), .overrun(overrun)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected results computed from the requirements
    task automatic model();
        longint cnt = 0, sum = 0, mx = 0, mn = 0, d = 0, ov = 0, mag;
        bit pend = 0;
        for (int i = 0; i < npix; i++) begin
            if (okf[i]) begin
                cnt++;
                sum += pix[i];
                if (cnt == 1) begin mx = pix[i]; mn = pix[i]; end
                else begin
                    if (pix[i] > mx) mx = pix[i];
                    if (pix[i] < mn) mn = pix[i];
                end
                if (pend) begin d += ov - longint'(pix[i]); pend = 0; end
                else begin pend = 1; ov = pix[i]; end
            end
        end
        if (cnt == 0) begin
            e_avg = 0; e_max = 0; e_min = 0; e_hi = 0; e_lo = 0;
            e_nonuni = 64'hFFFF_FFFF; e_imbal = 64'h7FFF_FFFF; e_err = 1;
        end else begin
            e_avg = sum / cnt; e_max = mx; e_min = mn;
            e_hi = mx - e_avg; e_lo = e_avg - mn;
            if (e_avg == 0) begin
                e_nonuni = 64'hFFFF_FFFF; e_imbal = 64'h7FFF_FFFF; e_err = 1;
            end else begin
                e_nonuni = ((e_hi > e_lo) ? e_hi : e_lo) * 25600 / e_avg;
                if (e_nonuni > 64'hFFFF_FFFF) e_nonuni = 64'hFFFF_FFFF;
                mag = 2 * ((d < 0) ? -d : d) * 25600 / sum;
                e_imbal = (d < 0) ? -mag : mag;
                e_err = 0;
            end
        end
    endtask

    task automatic send_line(input bit with_last);
        for (int i = 0; i < npix; i++) begin
            @(negedge clk);
            in_vld = 1; in_data = DW'(pix[i]); in_pix_ok = okf[i];
            in_first = (i == 0); in_last = with_last && (i == npix - 1);
        end
        @(negedge clk);
        in_vld = 0; in_first = 0; in_last = 0; in_pix_ok = 0;
    endtask

    task automatic wait_done(input string req);
        int k = 0;
        while (!res_done && k < 400) begin @(negedge clk); k++; end
        check({req, " done pulse"}, longint'(res_done), 1);
    endtask

    task automatic check_results(input string tag);
        model();
        check({tag, " R2 mean"}, longint'(res_avg), e_avg);
        check({tag, " R3 max"}, longint'(res_max), e_max);
        check({tag, " R3 min"}, longint'(res_min), e_min);
        check({tag, " R3 dev_hi"}, longint'(res_dev_hi), e_hi);
        check({tag, " R3 dev_lo"}, longint'(res_dev_lo), e_lo);
        check({tag, " R4 nonuni"}, longint'(res_nonuni), e_nonuni);
        check({tag, " R6 imbal"}, longint'(res_imbal), e_imbal);
        check({tag, " R8 err"}, longint'(res_err), e_err);
    endtask

    task automatic run_line(input string tag);
        send_line(1);
        wait_done(tag);
        check_results(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check("R11 done", longint'(res_done), 0);
        check("R11 mean", longint'(res_avg), 0);
        check("R11 nonuni", longint'(res_nonuni), 0);
        check("R11 imbal", longint'(res_imbal), 0);
        check("R11 err", longint'(res_err), 0);
        check("R11 overrun", longint'(overrun), 0);

        // R2: flat line
        npix = 10;
        for (int i = 0; i < npix; i++) begin pix[i] = 1000; okf[i] = 1; end
        run_line("flat");

        // R1: untagged samples carry extreme values
        npix = 14;
        for (int i = 0; i < npix; i++) begin
            okf[i] = (i >= 3 && i < 12);
            pix[i] = okf[i] ? 500 + 7 * i : ((i % 2) ? 65535 : 0);
        end
        run_line("R1 untagged");

        // R5: odd count, last tagged sample unpaired
        npix = 5;
        for (int i = 0; i < npix; i++) begin pix[i] = 10 * (i + 1); okf[i] = 1; end
        run_line("R5 odd count");
        check("R5 pair sign", longint'(res_imbal), -6826);

        // R8: all-zero line gives zero mean
        npix = 6;
        for (int i = 0; i < npix; i++) begin pix[i] = 0; okf[i] = 1; end
        run_line("R8 zeros");

        // R8: mean truncates to zero although the sum is not zero
        npix = 4;
        for (int i = 0; i < npix; i++) begin pix[i] = (i == 3); okf[i] = 1; end
        run_line("R8 tiny");

        // R8: no tagged samples at all
        npix = 5;
        for (int i = 0; i < npix; i++) begin pix[i] = 4000; okf[i] = 0; end
        run_line("R8 empty");

        // R12: an unfinished line is abandoned by a new first flag
        npix = 8;
        for (int i = 0; i < npix; i++) begin pix[i] = 60000; okf[i] = 1; end
        send_line(0);
        npix = 6;
        for (int i = 0; i < npix; i++) begin pix[i] = 200 + 3 * i; okf[i] = 1; end
        run_line("R12 restart");

        // R9: results hold after the pulse
        repeat (5) @(negedge clk);
        check("R9 pulse ends", longint'(res_done), 0);
        check("R9 mean holds", longint'(res_avg), e_avg);

        // R10: samples during the division window are dropped and flagged
        npix = 7;
        for (int i = 0; i < npix; i++) begin pix[i] = 300 + 11 * i; okf[i] = 1; end
        for (int i = 0; i < npix; i++) begin
            @(negedge clk);
            in_vld = 1; in_data = DW'(pix[i]); in_pix_ok = 1;
            in_first = (i == 0); in_last = (i == npix - 1);
        end
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            in_vld = 1; in_data = 16'hFFFF; in_pix_ok = 1; in_first = (j == 2); in_last = (j == 5);
        end
        @(negedge clk);
        in_vld = 0; in_first = 0; in_last = 0; in_pix_ok = 0;
        wait_done("R10");
        check_results("R10 dropped");
        check("R10 overrun set", longint'(overrun), 1);
        npix = 4;
        for (int i = 0; i < npix; i++) begin pix[i] = 800 + i; okf[i] = 1; end
        run_line("R10 next line");
        check("R10 overrun cleared", longint'(overrun), 0);

        // R7: full-length lines at the top of the range
        npix = 5150;
        for (int i = 0; i < npix; i++) begin pix[i] = 65535; okf[i] = 1; end
        run_line("R7 full");
        for (int i = 0; i < npix; i++) begin pix[i] = (i % 2) ? 0 : 65535; okf[i] = 1; end
        run_line("R7 alternate");
        check("R6 imbal limit", longint'(res_imbal), 51200);

        // Seeded random lines with shielded and dummy samples around them
        for (int l = 0; l < 24; l++) begin
            int unsigned base;
            npix = 8 + int'($urandom % 60);
            base = 50 + ($urandom % 5000);
            for (int i = 0; i < npix; i++) begin
                okf[i] = (i >= 3) && (i < npix - 2);
                pix[i] = okf[i] ? base + ($urandom % (1 + (l * 97) % 3000)) : ($urandom % 65536);
            end
            run_line($sformatf("random %0d", l));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule